// File: doc/BRIEF.md
# Double-Buffered SPI Master Engine

This block is an 8-bit SPI master for mode 0. It sits behind a few strobes and flags. Software places a byte in a transmit holding register, and the engine moves it into its shift register. The engine drives a serial clock that idles low. It puts data on MOSI on the falling clock edge and captures MISO on the rising edge, most significant bit first. When a byte is finished, the captured bits are copied into a receive holding register.

Both directions have a buffer stage. While one byte is on the wire, the next can already wait in the transmit holding register. That byte follows the current one with no idle clock period in between. On the receive side, the last finished byte stays readable until a newer one replaces it. Two handshake flags tell software when to act: one says the transmit holding register is empty, the other says the receive register is full. A busy flag shows when the wire is in use. A sticky overrun flag records that an unread byte was overwritten.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset, `rx_data` reads 0x00, `tx_empty` is 1, and `rx_full`, `busy`, `overrun` and `sclk` are all 0.
- R2: A `tx_wr` while the engine is idle and `tx_empty` is 1 drives `tx_empty` low for exactly one cycle. On the next clock edge the byte enters the shift register, `busy` goes high and `tx_empty` returns to 1.
- R3: A byte written while a transfer runs waits in the holding register, and `tx_empty` stays 0 until the running byte ends. It is then sent straight after, so the spacing between consecutive rising SCLK edges stays DIV system clocks across the byte boundary.
- R4: A `tx_wr` while `tx_empty` is 0 is ignored: the byte is never transmitted and `tx_empty` stays 0.
- R5: Bits are shifted most significant bit first. MOSI changes only on a falling SCLK edge (or when a byte is loaded), and MISO is sampled on the rising SCLK edge.
- R6: SCLK is low whenever no transfer runs. During a transfer, each SCLK high and low phase lasts DIV/2 system clock cycles.
- R7: When the eighth bit of a byte completes, the received byte appears on `rx_data` and `rx_full` is set.
- R8: A `rx_rd` strobe clears `rx_full`. A `rx_wr` strobe also clears `rx_full` and leaves `rx_data` unchanged.
- R9: If a byte completes in the same cycle as a `rx_rd` or `rx_wr` strobe, `rx_full` ends up set and `overrun` is not set.
- R10: If a byte completes while `rx_full` is 1 and no clear strobe is present, `rx_data` is overwritten and `overrun` is set. `overrun` stays set until reset.
- R11: `busy` is high from the cycle after a byte enters the shifter until the final falling SCLK edge of a byte with no pending transmit data, and it does not drop between back-to-back bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | W | Byte to transmit, taken when `tx_wr` is accepted |
| rx_rd | input | 1 | Read strobe for the receive register; clears `rx_full` |
| rx_wr | input | 1 | Write strobe for the receive register; clears `rx_full` only |
| rx_data | output | W | Receive holding register |
| tx_empty | output | 1 | Transmit holding register may be written |
| rx_full | output | 1 | An unread received byte is present |
| busy | output | 1 | A transfer is running on the wire |
| overrun | output | 1 | Sticky: an unread byte was overwritten |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two events can land on the same clock edge: a byte completing into the receive register, and software clearing `rx_full` with a read or write strobe. The bench leaves one byte unread and starts a second one. It counts rising SCLK edges to find the exact cycle of the final falling edge, and raises `rx_rd` for that one cycle only. Afterwards `rx_full` must be set, `overrun` must still be clear, and `rx_data` must hold the second byte. A separate run omits the strobe and must set `overrun`.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
    // Default configuration shared by the engine and its users.
    localparam int SPI_DEF_W   = 8;
    localparam int SPI_DEF_DIV = 4;

    // Width of a bit counter that indexes a byte of width w.
    function automatic int bit_idx_w(input int w);
        return (w > 2) ? $clog2(w) : 1;
    endfunction
endpackage

// File: rtl/spi_sclk_timer.sv
module spi_sclk_timer #(
    parameter int DIV = spi_dbuf_pkg::SPI_DEF_DIV
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_evt,
    output logic fall_evt
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          lvl;
    } tmr_t;

    tmr_t tmr_q, tmr_d;
    logic edge_now;

    always_comb begin
        edge_now = run && (tmr_q.cnt == CW'(HALF - 1));
        tmr_d    = tmr_q;
        if (!run) begin
            tmr_d.cnt = '0;
            tmr_d.lvl = 1'b0;
        end else if (edge_now) begin
            tmr_d.cnt = '0;
            tmr_d.lvl = ~tmr_q.lvl;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign sclk     = tmr_q.lvl;
    assign rise_evt = edge_now & ~tmr_q.lvl;
    assign fall_evt = edge_now &  tmr_q.lvl;

    // R6: clock parks low when the engine is idle
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);
    // R6: level only moves on a counted half-period boundary
    p_half_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !edge_now) |=> $stable(sclk));
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit #(
    parameter int W = spi_dbuf_pkg::SPI_DEF_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         rise_evt,
    input  logic         fall_evt,
    input  logic         miso,
    output logic         mosi,
    output logic         last_bit,
    output logic [W-1:0] rx_byte
);
    localparam int BW = spi_dbuf_pkg::bit_idx_w(W);

    typedef struct packed {
        logic [W-1:0]  txs;
        logic [W-1:0]  rxs;
        logic [BW-1:0] bits;
    } shf_t;

    shf_t shf_q, shf_d;
    logic at_last;

    always_comb begin
        at_last = (shf_q.bits == BW'(W - 1));
        shf_d   = shf_q;
        if (load) begin
            shf_d.txs  = load_data;
            shf_d.bits = '0;
        end else if (fall_evt && !at_last) begin
            shf_d.txs  = {shf_q.txs[W-2:0], 1'b0};
            shf_d.bits = shf_q.bits + 1'b1;
        end
        if (rise_evt) begin
            shf_d.rxs = {shf_q.rxs[W-2:0], miso};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shf_q <= '0;
        else        shf_q <= shf_d;
    end

    assign mosi     = shf_q.txs[W-1];
    assign last_bit = at_last;
    assign rx_byte  = shf_q.rxs;

    // R5: output bit only moves on a falling edge or a fresh load
    p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !fall_evt) |=> $stable(mosi));
    // R5: a load never meets a sampling edge
    p_no_load_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && rise_evt));
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master #(
    parameter int W   = spi_dbuf_pkg::SPI_DEF_W,
    parameter int DIV = spi_dbuf_pkg::SPI_DEF_DIV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_data,
    input  logic         rx_rd,
    input  logic         rx_wr,
    output logic [W-1:0] rx_data,
    output logic         tx_empty,
    output logic         rx_full,
    output logic         busy,
    output logic         overrun,
    output logic         sclk,
    output logic         mosi,
    input  logic         miso
);
    typedef struct packed {
        logic [W-1:0] hold;
        logic         hold_v;
        logic         active;
        logic [W-1:0] rxr;
        logic         rx_full;
        logic         ovr;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic         rise_evt, fall_evt, last_bit;
    logic [W-1:0] rx_byte;
    logic         done, load, clr;

    spi_sclk_timer #(.DIV(DIV)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctl_q.active),
        .sclk     (sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    spi_shift_unit #(.W(W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (ctl_q.hold),
        .rise_evt  (rise_evt),
        .fall_evt  (fall_evt),
        .miso      (miso),
        .mosi      (mosi),
        .last_bit  (last_bit),
        .rx_byte   (rx_byte)
    );

    always_comb begin
        done  = fall_evt & last_bit;
        load  = ctl_q.hold_v & (~ctl_q.active | done);
        clr   = rx_rd | rx_wr;
        ctl_d = ctl_q;

        // shifter hand-off; back-to-back keeps the engine running
        if (load) begin
            ctl_d.hold_v = 1'b0;
            ctl_d.active = 1'b1;
        end else if (done) begin
            ctl_d.active = 1'b0;
        end

        // holding register only accepts a byte while empty
        if (tx_wr && !ctl_q.hold_v) begin
            ctl_d.hold   = tx_data;
            ctl_d.hold_v = 1'b1;
        end

        // receive side: completion outranks a same-cycle clear
        if (clr) begin
            ctl_d.rx_full = 1'b0;
        end
        if (done) begin
            ctl_d.rxr     = rx_byte;
            ctl_d.rx_full = 1'b1;
            if (ctl_q.rx_full && !clr) begin
                ctl_d.ovr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rx_data  = ctl_q.rxr;
    assign tx_empty = ~ctl_q.hold_v;
    assign rx_full  = ctl_q.rx_full;
    assign busy     = ctl_q.active;
    assign overrun  = ctl_q.ovr;

    // R2: an accepted write marks the holding register occupied
    p_empty_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && tx_empty) |=> !tx_empty);
    // R4: a write into an occupied holding register is dropped
    p_ignored_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && !tx_empty) |=> $stable(ctl_q.hold));
    // R7: completion raises the full flag
    p_full_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);
    // R8: a clear with no completion empties the receive flag
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !done) |=> !rx_full);
    // R9: collision of clear and completion never flags overrun
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && done && !overrun) |=> !overrun);
    // R10: overrun is sticky
    p_overrun_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);
    // R11: last byte with nothing pending ends the busy window
    p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && tx_empty) |=> !busy);
    // R11: pending data at completion keeps the engine busy
    p_busy_chain_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !tx_empty) |=> busy);
endmodule

// File: tb/tb_spi_dbuf_master.sv
`timescale 1ns/1ps
module tb_spi_dbuf_master;
    localparam int W    = 8;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;
    localparam int TCLK = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tx_wr = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         rx_rd = 1'b0;
    logic         rx_wr = 1'b0;
    logic [W-1:0] rx_data;
    logic         tx_empty, rx_full, busy, overrun, sclk, mosi, miso;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    spi_dbuf_master #(.W(W), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .rx_wr(rx_wr), .rx_data(rx_data),
        .tx_empty(tx_empty), .rx_full(rx_full), .busy(busy),
        .overrun(overrun), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    // Byte the slave returns for the k-th transfer
    function automatic logic [W-1:0] slave_val(input int k);
        return W'((k * 73 + 29) % 256);
    endfunction

    // Mode-0 slave model and edge timing monitor
    logic [W-1:0] s_reg;
    logic [W-1:0] cap = '0;
    logic [W-1:0] mlog [0:511];
    int  rbits = 0, mcount = 0, sidx = 1, rise_total = 0;
    int  half_err = 0, gap_err = 0;
    bit  spacing_chk = 1'b0, prev_ok = 1'b0;
    time prev_rise = 0;

    initial s_reg = slave_val(0);
    assign miso = s_reg[W-1];

    always @(posedge sclk) begin
        logic [W-1:0] nc;
        nc = {cap[W-2:0], mosi};
        cap = nc;
        rise_total++;
        if (spacing_chk && prev_ok && ($time - prev_rise) != DIV * TCLK) gap_err++;
        prev_rise = $time;
        prev_ok   = 1'b1;
        rbits++;
        if (rbits == W) begin
            mlog[mcount] = nc;
            mcount++;
        end
    end

    always @(negedge sclk) begin
        if (($time - prev_rise) != HALF * TCLK) half_err++;
        if (rbits == W) begin
            rbits = 0;
            s_reg = slave_val(sidx);
            sidx++;
        end else begin
            s_reg = {s_reg[W-2:0], 1'b0};
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic write_tx(input logic [W-1:0] v);
        @(negedge clk);
        tx_wr = 1'b1; tx_data = v;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    task automatic pulse_rd();
        @(negedge clk); rx_rd = 1'b1;
        @(negedge clk); rx_rd = 1'b0;
    endtask

    task automatic pulse_rwr();
        @(negedge clk); rx_wr = 1'b1;
        @(negedge clk); rx_wr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || !tx_empty);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
        check(tx_empty == 1'b1, "R1 tx_empty", tx_empty, 1);
        check({rx_full, busy, overrun, sclk} == 4'b0, "R1 flags", {rx_full, busy, overrun, sclk}, 0);

        // R2 idle write timing, R11 busy start
        @(negedge clk); tx_wr = 1'b1; tx_data = 8'hA5;
        @(negedge clk); tx_wr = 1'b0;
        check(tx_empty == 1'b0, "R2 empty low after write", tx_empty, 0);
        check(busy == 1'b0, "R11 not yet busy", busy, 0);
        @(negedge clk);
        check(tx_empty == 1'b1, "R2 empty restored", tx_empty, 1);
        check(busy == 1'b1, "R11 busy after load", busy, 1);
        wait_idle();
        check(mlog[0] == 8'hA5, "R5 MSB-first mosi", mlog[0], 8'hA5);
        check(rx_full == 1'b1, "R7 full set", rx_full, 1);
        check(rx_data == slave_val(0), "R7 rx byte", rx_data, slave_val(0));
        check(sclk == 1'b0, "R6 idle low", sclk, 0);
        // R8 write-strobe clear keeps data
        pulse_rwr();
        check(rx_full == 1'b0, "R8 rx_wr clears", rx_full, 0);
        check(rx_data == slave_val(0), "R8 rx_wr keeps data", rx_data, slave_val(0));

        // Full sweep of transmit byte values
        for (int v = 0; v < 256; v++) begin
            k = mcount;
            write_tx(W'(v));
            wait_idle();
            check(mcount == k + 1 && mlog[k] == W'(v), "R5 sweep mosi", mlog[k], v);
            check(rx_data == slave_val(k), "R7 sweep rx", rx_data, slave_val(k));
            check(rx_full == 1'b1, "R7 sweep full", rx_full, 1);
            pulse_rd();
            check(rx_full == 1'b0, "R8 rx_rd clears", rx_full, 0);
            check(overrun == 1'b0, "R10 no false overrun", overrun, 0);
        end

        // R9 completion and read in the same cycle
        k = mcount;
        write_tx(8'h5A);
        wait_idle();
        begin
            int r0;
            r0 = rise_total;
            @(negedge clk); tx_wr = 1'b1; tx_data = 8'h96;
            @(negedge clk); tx_wr = 1'b0;
            while (rise_total != r0 + W) @(negedge clk);
            repeat (HALF - 1) @(negedge clk);
            rx_rd = 1'b1;
            @(negedge clk); rx_rd = 1'b0;
        end
        check(rx_full == 1'b1, "R9 full survives", rx_full, 1);
        check(overrun == 1'b0, "R9 no overrun", overrun, 0);
        check(rx_data == slave_val(k + 1), "R9 newest byte", rx_data, slave_val(k + 1));
        check(busy == 1'b0, "R11 idle after last", busy, 0);
        pulse_rd();

        // R3 back-to-back, R4 ignored write, R10 overrun
        k = mcount;
        spacing_chk = 1'b1; prev_ok = 1'b0;
        write_tx(8'h3C);
        @(negedge clk);
        write_tx(8'hC3);
        check(tx_empty == 1'b0, "R3 held while running", tx_empty, 0);
        write_tx(8'h77);
        check(tx_empty == 1'b0, "R4 empty stays low", tx_empty, 0);
        begin
            int drops;
            drops = 0;
            while (mcount < k + 2) begin
                @(negedge clk);
                if (!busy && mcount < k + 2) drops++;
            end
            check(drops == 0, "R11 busy continuous", drops, 0);
        end
        wait_idle();
        spacing_chk = 1'b0;
        repeat (3 * DIV) @(negedge clk);
        check(mcount == k + 2, "R4 ignored byte not sent", mcount - k, 2);
        check(mlog[k] == 8'h3C, "R3 first byte", mlog[k], 8'h3C);
        check(mlog[k + 1] == 8'hC3, "R3 second byte", mlog[k + 1], 8'hC3);
        check(gap_err == 0, "R3 no gap between bytes", gap_err, 0);
        check(overrun == 1'b1, "R10 overrun set", overrun, 1);
        check(rx_data == slave_val(k + 1), "R10 overwritten", rx_data, slave_val(k + 1));
        pulse_rd();
        repeat (2) @(negedge clk);
        check(overrun == 1'b1, "R10 sticky", overrun, 1);
        check(half_err == 0, "R6 half period", half_err, 0);
        check(sclk == 1'b0, "R6 idle low end", sclk, 0);
        summary();
    end
endmodule